// File: doc/BRIEF.md
# UART Interrupt Identification Controller

This block is the interrupt front end of a 16550-style serial port. It holds a pending flag for each of four interrupt causes: a receiver error or break, a received byte, the transmit holding register going empty, and a change on the modem lines. Each cause is masked by its own enable bit. The highest-priority unmasked cause is reported as a four-bit identification value. A single interrupt request pin is raised whenever a cause is reported and the OUT2 control bit is set.

Software reaches the block over a simple register strobe bus: one read strobe, one write strobe, a three-bit register offset and four bits of write data. The block keeps only the enable register and the OUT2 bit itself. Every other register access is decoded purely for its side effect on the pending flags. A line-status read, a data read, a modem-status read, a data write or an identification read each services exactly one cause. The receiver, the transmitter and the modem-line logic feed the block with one-cycle event pulses and with the transmit-empty levels.

Top module: `uart_irq_ident`

## Requirements
- R1: A pulse on `line_err_evt` latches the line-status cause. It is reported as identification 4'b0110 when enable bit 2 is set. Only a read of offset 5 clears it. Reads of offsets 0, 2 and 6 leave it pending.
- R2: A pulse on `rx_byte_evt` latches the received-data cause. It is reported as 4'b0100 when enable bit 0 is set. A read of offset 0 clears it, and a read of offset 5 does not.
- R3: A rising edge on `thre` latches the transmit-empty cause, which is reported as 4'b0010 when enable bit 1 is set. It is cleared by a write to offset 0, or by a read of offset 2 in a cycle where it is the reported cause. An offset-2 read while a higher cause is reported leaves it pending.
- R4: When enable bit 1 goes from 0 to 1 while `thre` is high, the transmit-empty cause is latched again. It is reported one cycle after the enable register has taken the new value.
- R5: The `temt` input never latches, reports or requests an interrupt.
- R6: A pulse on `modem_chg_evt` latches the modem cause. It is reported as 4'b0000 when enable bit 3 is set. Only a read of offset 6 clears it.
- R7: Priority from high to low is line status, received data, transmit empty, modem. With nothing reported the identification is 4'b0001. Bit 3 always reads 0.
- R8: A cause whose enable bit is 0 is neither reported nor able to raise `irq`. It stays latched, so setting its enable bit later reports it.
- R9: `irq` is high exactly when a cause is reported and OUT2 (bit 3 of a write to offset 4) is set.
- R10: After reset the enables and OUT2 are 0 and nothing is pending: identification 4'b0001, `irq` low.
- R11: When a cause's event and its clearing access fall in the same cycle, the cause ends up pending.
- Writes to offset 1 load the enable register from `acc_wdata[3:0]`. All flags update on the rising clock edge, and the outputs follow the registered state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_rd | input | 1 | Register read strobe, one cycle per access |
| acc_wr | input | 1 | Register write strobe, one cycle per access |
| acc_addr | input | 3 | Register offset (0 data, 1 enable, 2 identification, 4 modem control, 5 line status, 6 modem status) |
| acc_wdata | input | 4 | Write data (enable bits, or OUT2 in bit 3) |
| line_err_evt | input | 1 | Receiver error or break detected |
| rx_byte_evt | input | 1 | A received byte became available |
| thre | input | 1 | Transmit holding register empty level |
| temt | input | 1 | Transmitter fully empty level |
| modem_chg_evt | input | 1 | A modem input line changed |
| iid | output | 4 | Identification value of the reported cause |
| irq | output | 1 | Interrupt request |

## Verification
Each cause is first raised alone and followed by the clearing access of every other cause. This separates the correct clearing offset from a wrong one. All four causes are then raised in the same cycle and serviced one at a time, which exposes any mistake in the priority order or the codes. Further directed passes set an enable bit late with `thre` already high, toggle `temt` alone, mask causes and OUT2, and place a clearing access in the same cycle as a new event. A long pseudo-random run of strobes, offsets, events and level changes is then compared against a behavioural model on every clock.

// File: rtl/uart_irq_pkg.sv
// Shared constants for the UART interrupt identification controller.
// Assumes a 3-bit register offset and the conventional priority order.
package uart_irq_pkg;
    localparam int ADDR_W = 3;
    localparam int WDAT_W = 4;
    localparam int NSRC   = 4;                 // causes, index 0 = highest
    localparam int CODE_W = $clog2(NSRC);
    localparam int IID_W  = CODE_W + 2;

    // register offsets whose access has a side effect
    localparam logic [ADDR_W-1:0] OFS_DATA = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_EN   = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_IID  = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_MCR  = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_LSR  = 3'd5;
    localparam logic [ADDR_W-1:0] OFS_MSR  = 3'd6;

    // enable register bit positions
    localparam int EN_RX   = 0;
    localparam int EN_THRE = 1;
    localparam int EN_LINE = 2;
    localparam int EN_MDM  = 3;
    localparam int OUT2_BIT = 3;

    // priority slots
    typedef enum int {
        SLOT_LINE = 0,
        SLOT_RX   = 1,
        SLOT_THRE = 2,
        SLOT_MDM  = 3
    } slot_e;
endpackage

// File: rtl/uart_irq_regs.sv
// Access decoder: holds the enable register and the OUT2 bit, and turns
// bus strobes into one-cycle side-effect pulses for the cause flags.
// Assumes each strobe is high for one cycle per access.
module uart_irq_regs
    import uart_irq_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = WDAT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_rd,
    input  logic          acc_wr,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] acc_wdata,
    output logic [DW-1:0] en_q,
    output logic          out2_q,
    output logic          rd_data,
    output logic          rd_iid,
    output logic          rd_lsr,
    output logic          rd_msr,
    output logic          wr_data
);
    // decode side-effect pulses from the current access
    always_comb begin
        rd_data = acc_rd && (acc_addr == OFS_DATA);
        rd_iid  = acc_rd && (acc_addr == OFS_IID);
        rd_lsr  = acc_rd && (acc_addr == OFS_LSR);
        rd_msr  = acc_rd && (acc_addr == OFS_MSR);
        wr_data = acc_wr && (acc_addr == OFS_DATA);
    end

    // hold the enable register
    always_ff @(posedge clk) begin
        if (!rst_n)                                en_q <= '0;
        else if (acc_wr && (acc_addr == OFS_EN))   en_q <= acc_wdata;
    end

    // hold the OUT2 request gate
    always_ff @(posedge clk) begin
        if (!rst_n)                                out2_q <= 1'b0;
        else if (acc_wr && (acc_addr == OFS_MCR))  out2_q <= acc_wdata[OUT2_BIT];
    end
endmodule

// File: rtl/uart_irq_sticky.sv
// Bank of event-latched cause flags. Each flag sets on its event pulse
// and clears on its service pulse; the event wins when both coincide.
module uart_irq_sticky #(
    parameter int NUM = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] set_i,
    input  logic [NUM-1:0] clr_i,
    output logic [NUM-1:0] pend_q
);
    for (genvar g = 0; g < NUM; g++) begin : g_flag
        // latch one cause until serviced
        always_ff @(posedge clk) begin
            if (!rst_n)         pend_q[g] <= 1'b0;
            else if (set_i[g])  pend_q[g] <= 1'b1;
            else if (clr_i[g])  pend_q[g] <= 1'b0;
        end

        // R11
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> pend_q[g]);
        // R1 R2 R6
        clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !set_i[g]) |=> !pend_q[g]);
    end
endmodule

// File: rtl/uart_irq_thre.sv
// Transmit-empty cause flag. Arms on a rising THRE level, or when the
// cause's enable goes high with THRE already high; clears on a data
// write or on an identification read that reports this cause.
module uart_irq_thre (
    input  logic clk,
    input  logic rst_n,
    input  logic thre,
    input  logic en,
    input  logic clr_wr,
    input  logic clr_iid,
    output logic pend_q
);
    logic thre_d, en_d, arm;

    // remember previous THRE and enable levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thre_d <= 1'b0;
            en_d   <= 1'b0;
        end else begin
            thre_d <= thre;
            en_d   <= en;
        end
    end

    // form the arm condition from the two edges
    always_comb arm = thre && (!thre_d || (en && !en_d));

    // latch the cause until serviced
    always_ff @(posedge clk) begin
        if (!rst_n)                 pend_q <= 1'b0;
        else if (arm)               pend_q <= 1'b1;
        else if (clr_wr || clr_iid) pend_q <= 1'b0;
    end

    // R3
    thre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_wr || clr_iid) && !arm) |=> !pend_q);
    // R4
    thre_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(en) && thre) |=> pend_q);
endmodule

// File: rtl/uart_irq_prio.sv
// Fixed-priority encoder: picks the lowest-index pending and enabled
// cause and forms the identification value (bit 0 = none pending,
// bits CODE_W:1 = NSRC-1-slot, top bit 0).
module uart_irq_prio
    import uart_irq_pkg::*;
#(
    parameter int N  = NSRC,
    parameter int CW = CODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  pend,
    input  logic [N-1:0]  en,
    output logic [N-1:0]  grant,
    output logic [CW+1:0] iid,
    output logic          any
);
    logic [N-1:0]  act;
    logic [CW-1:0] code;

    // select the winning cause by slot order
    always_comb begin
        act   = pend & en;
        grant = '0;
        code  = '0;
        any   = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (act[i] && !any) begin
                grant[i] = 1'b1;
                code     = CW'(N - 1 - i);
                any      = 1'b1;
            end
        end
        iid = {1'b0, code, !any};
    end

    // R7
    one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R8
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & en) == '0) |-> (iid == {{(CW+1){1'b0}}, 1'b1}));
endmodule

// File: rtl/uart_irq_ident.sv
// Top: interrupt identification controller for a 16550-style UART.
// Collects line-status, received-data, transmit-empty and modem causes,
// reports the winner and drives the OUT2-gated request. Assumes event
// inputs are one-cycle pulses synchronous to clk.
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = WDAT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_rd,
    input  logic          acc_wr,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] acc_wdata,
    input  logic          line_err_evt,
    input  logic          rx_byte_evt,
    input  logic          thre,
    input  logic          temt,
    input  logic          modem_chg_evt,
    output logic [3:0]    iid,
    output logic          irq
);
    localparam int NSTK = 3;

    logic [DW-1:0]   en_q;
    logic            out2_q, rd_data, rd_iid, rd_lsr, rd_msr, wr_data;
    logic [NSTK-1:0] stk_set, stk_clr, stk_pend;
    logic            thre_pend;
    logic [NSRC-1:0] pend_v, en_v, grant;
    logic [IID_W-1:0] iid_w;
    logic            any;

    uart_irq_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .acc_rd(acc_rd), .acc_wr(acc_wr),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .en_q(en_q), .out2_q(out2_q),
        .rd_data(rd_data), .rd_iid(rd_iid), .rd_lsr(rd_lsr),
        .rd_msr(rd_msr), .wr_data(wr_data)
    );

    // route events and services to the sticky bank: line, rx, modem
    always_comb begin
        stk_set = {modem_chg_evt, rx_byte_evt, line_err_evt};
        stk_clr = {rd_msr, rd_data, rd_lsr};
    end

    uart_irq_sticky #(.NUM(NSTK)) u_stk (
        .clk(clk), .rst_n(rst_n),
        .set_i(stk_set), .clr_i(stk_clr), .pend_q(stk_pend)
    );

    uart_irq_thre u_thre (
        .clk(clk), .rst_n(rst_n), .thre(thre),
        .en(en_q[EN_THRE]), .clr_wr(wr_data),
        .clr_iid(rd_iid && grant[SLOT_THRE]),
        .pend_q(thre_pend)
    );

    // arrange flags and enables in priority slot order
    always_comb begin
        pend_v[SLOT_LINE] = stk_pend[0];
        pend_v[SLOT_RX]   = stk_pend[1];
        pend_v[SLOT_THRE] = thre_pend;
        pend_v[SLOT_MDM]  = stk_pend[2];
        en_v[SLOT_LINE]   = en_q[EN_LINE];
        en_v[SLOT_RX]     = en_q[EN_RX];
        en_v[SLOT_THRE]   = en_q[EN_THRE];
        en_v[SLOT_MDM]    = en_q[EN_MDM];
    end

    uart_irq_prio #(.N(NSRC), .CW(CODE_W)) u_prio (
        .clk(clk), .rst_n(rst_n), .pend(pend_v), .en(en_v),
        .grant(grant), .iid(iid_w), .any(any)
    );

    // drive the outputs
    always_comb begin
        iid = iid_w;
        irq = any && out2_q;
    end

    // R1
    lsr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && acc_addr == OFS_LSR && !line_err_evt) |=> (iid != 4'b0110));
    // R2
    data_rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && acc_addr == OFS_DATA && !rx_byte_evt && !line_err_evt)
        |=> (iid != 4'b0100));
    // R6
    msr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && acc_addr == OFS_MSR && !modem_chg_evt) |=> (iid != 4'b0000));
    // R9
    out2_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && acc_addr == OFS_MCR && !acc_wdata[OUT2_BIT]) |=> !irq);
    // R5
    temt_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(temt) && $stable(thre) && $stable(en_q) && !acc_rd && !acc_wr
         && !line_err_evt && !rx_byte_evt && !modem_chg_evt) |=> $stable(iid));
endmodule

// File: tb/sim_uart_irq_ident.sv
// Bench: behavioural reference model compared on every clock, plus
// directed checks with fixed expected values.
module sim_uart_irq_ident;
    localparam int CLK_NS = 10;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       acc_rd = 0, acc_wr = 0;
    logic [2:0] acc_addr = 0;
    logic [3:0] acc_wdata = 0;
    logic       line_err_evt = 0, rx_byte_evt = 0, thre = 0, temt = 0, modem_chg_evt = 0;
    logic [3:0] iid;
    logic       irq;

    int    n_chk = 0, n_bad = 0;
    string cur_req = "R10";
    bit    done = 0;

    uart_irq_ident u0 (
        .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_wr(acc_wr),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .line_err_evt(line_err_evt), .rx_byte_evt(rx_byte_evt),
        .thre(thre), .temt(temt), .modem_chg_evt(modem_chg_evt),
        .iid(iid), .irq(irq)
    );

    always #(CLK_NS/2) clk = ~clk;

    // reference model state
    bit       m_ls, m_rx, m_th, m_ms, m_out2, m_thre_d, m_en1_d;
    bit [3:0] m_en;

    function automatic int m_winner();
        if (m_ls && m_en[2]) return 0;
        if (m_rx && m_en[0]) return 1;
        if (m_th && m_en[1]) return 2;
        if (m_ms && m_en[3]) return 3;
        return -1;
    endfunction

    function automatic logic [3:0] m_iid();
        case (m_winner())
            0: return 4'b0110;
            1: return 4'b0100;
            2: return 4'b0010;
            3: return 4'b0000;
            default: return 4'b0001;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ls = 0; m_rx = 0; m_th = 0; m_ms = 0; m_out2 = 0;
            m_thre_d = 0; m_en1_d = 0; m_en = 0;
        end else begin
            int  w;
            bit  arm;
            w = m_winner();
            if (line_err_evt) m_ls = 1; else if (acc_rd && acc_addr == 5) m_ls = 0;
            if (rx_byte_evt) m_rx = 1; else if (acc_rd && acc_addr == 0) m_rx = 0;
            if (modem_chg_evt) m_ms = 1; else if (acc_rd && acc_addr == 6) m_ms = 0;
            arm = thre && (!m_thre_d || (m_en[1] && !m_en1_d));
            if (arm) m_th = 1;
            else if ((acc_wr && acc_addr == 0) || (acc_rd && acc_addr == 2 && w == 2)) m_th = 0;
            m_thre_d = thre;
            m_en1_d  = m_en[1];
            if (acc_wr && acc_addr == 1) m_en = acc_wdata;
            if (acc_wr && acc_addr == 4) m_out2 = acc_wdata[3];
        end
    end

    task automatic chk(string req, logic [3:0] got_iid, logic got_irq,
                       logic [3:0] exp_iid, logic exp_irq);
        n_chk++;
        if (got_iid !== exp_iid || got_irq !== exp_irq) begin
            n_bad++;
            $display("FAIL %s: iid=%b irq=%b expected iid=%b irq=%b at %0t",
                     req, got_iid, got_irq, exp_iid, exp_irq, $time);
        end
    endtask

    // compare against the model on every clock, away from the edge
    always @(negedge clk) begin
        if (rst_n && !done)
            chk(cur_req, iid, irq, m_iid(), m_out2 && (m_winner() >= 0));
    end

    // one bus cycle with optional event pulses, starting at a negedge
    task automatic op(bit rd, bit wr, logic [2:0] a, logic [3:0] d,
                      bit le = 0, bit rx = 0, bit mc = 0);
        acc_rd = rd; acc_wr = wr; acc_addr = a; acc_wdata = d;
        line_err_evt = le; rx_byte_evt = rx; modem_chg_evt = mc;
        @(negedge clk);
        acc_rd = 0; acc_wr = 0; acc_addr = 0; acc_wdata = 0;
        line_err_evt = 0; rx_byte_evt = 0; modem_chg_evt = 0;
    endtask

    task automatic idle(); op(0, 0, 0, 0); endtask
    task automatic rd(logic [2:0] a); op(1, 0, a, 0); endtask
    task automatic wr(logic [2:0] a, logic [3:0] d); op(0, 1, a, d); endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        bit [15:0] lfsr = 16'hACE1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R10", iid, irq, 4'b0001, 1'b0);

        cur_req = "R9";
        wr(4, 4'b1000);
        wr(1, 4'hF);

        cur_req = "R1";
        op(0, 0, 0, 0, 1);
        chk("R1", iid, irq, 4'b0110, 1'b1);
        rd(0); rd(2); rd(6);
        chk("R1", iid, irq, 4'b0110, 1'b1);
        rd(5);
        chk("R1", iid, irq, 4'b0001, 1'b0);

        cur_req = "R2";
        op(0, 0, 0, 0, 0, 1);
        chk("R2", iid, irq, 4'b0100, 1'b1);
        rd(5);
        chk("R2", iid, irq, 4'b0100, 1'b1);
        rd(0);
        chk("R2", iid, irq, 4'b0001, 1'b0);

        cur_req = "R6";
        op(0, 0, 0, 0, 0, 0, 1);
        chk("R6", iid, irq, 4'b0000, 1'b1);
        rd(5); rd(0);
        chk("R6", iid, irq, 4'b0000, 1'b1);
        rd(6);
        chk("R6", iid, irq, 4'b0001, 1'b0);

        cur_req = "R3";
        thre = 1; idle();
        chk("R3", iid, irq, 4'b0010, 1'b1);
        wr(0, 4'h5);
        chk("R3", iid, irq, 4'b0001, 1'b0);
        thre = 0; idle(); thre = 1; idle();
        chk("R3", iid, irq, 4'b0010, 1'b1);
        rd(2);
        chk("R3", iid, irq, 4'b0001, 1'b0);
        thre = 0; idle(); thre = 1;
        op(0, 0, 0, 0, 1);
        chk("R3", iid, irq, 4'b0110, 1'b1);
        rd(2);
        chk("R3", iid, irq, 4'b0110, 1'b1);
        rd(5);
        chk("R3", iid, irq, 4'b0010, 1'b1);
        wr(0, 0);
        chk("R3", iid, irq, 4'b0001, 1'b0);

        cur_req = "R4";
        wr(1, 4'b1101);
        wr(1, 4'hF);
        idle();
        chk("R4", iid, irq, 4'b0010, 1'b1);
        wr(0, 0);
        chk("R4", iid, irq, 4'b0001, 1'b0);

        cur_req = "R5";
        for (int k = 0; k < 6; k++) begin
            temt = ~temt; idle();
            chk("R5", iid, irq, 4'b0001, 1'b0);
        end
        thre = 0; idle();

        cur_req = "R8";
        wr(1, 4'h0);
        op(0, 0, 0, 0, 1);
        chk("R8", iid, irq, 4'b0001, 1'b0);
        wr(1, 4'b0100);
        chk("R8", iid, irq, 4'b0110, 1'b1);
        rd(5);
        wr(1, 4'hF);

        cur_req = "R9";
        wr(4, 4'b0000);
        op(0, 0, 0, 0, 0, 1);
        chk("R9", iid, irq, 4'b0100, 1'b0);
        wr(4, 4'b1000);
        chk("R9", iid, irq, 4'b0100, 1'b1);
        rd(0);

        cur_req = "R7";
        thre = 1;
        op(0, 0, 0, 0, 1, 1, 1);
        chk("R7", iid, irq, 4'b0110, 1'b1);
        rd(5);
        chk("R7", iid, irq, 4'b0100, 1'b1);
        rd(0);
        chk("R7", iid, irq, 4'b0010, 1'b1);
        rd(2);
        chk("R7", iid, irq, 4'b0000, 1'b1);
        rd(6);
        chk("R7", iid, irq, 4'b0001, 1'b0);

        cur_req = "R11";
        op(0, 0, 0, 0, 1);
        op(1, 0, 5, 0, 1);
        chk("R11", iid, irq, 4'b0110, 1'b1);
        rd(5);
        chk("R11", iid, irq, 4'b0001, 1'b0);

        cur_req = "R7";
        for (int k = 0; k < 3000; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[3:0] == 0) thre = ~thre;
            if (lfsr[5:4] == 0) temt = ~temt;
            op(lfsr[6] & lfsr[7], lfsr[8] & !(lfsr[6] & lfsr[7]) & lfsr[9],
               lfsr[12:10], lfsr[15:12],
               lfsr[13] & lfsr[2], lfsr[14] & lfsr[1], lfsr[15] & lfsr[0] & lfsr[5]);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule